// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches a 32-bit processor's instruction fetches and memory accesses for addresses that software has marked as breakpoints. It holds two instruction watch sets and two data watch sets. Each set is an address register and a control register that carries the enable bits and a don't-care mask. Software reaches all of them through a small register bus, and only while a unit-enable input from the coprocessor control word is high.

A fetch that hits an armed instruction set raises an instruction debug trap. This happens even when the instruction is being nullified. A memory access that hits a data set raises a data debug trap if the access type matches the set's read or write enable and the access is not nullified. Both traps are gated by a global debug-enable input and by two one-shot disable inputs, one for each trap type. The pipeline supplies these three inputs from its status word. Each trap appears one cycle after the access, with its interruption number and the address that caused it.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, no trap and no assist request is signalled, and every watch register reads back as zero.
- R2: Register index map: 0/2 are the instruction set 0/1 addresses, 1/3 the instruction set 0/1 controls, 4/6 the data set 0/1 addresses, 5/7 the data set 0/1 controls. In a control word, data bit 31 is the instruction enable or the data read enable, data bit 30 is the data write enable, and bits 23:0 are the mask. All other control bits read as zero. A read returns the word on `bus_rdata` one cycle later.
- R3: A fetch raises `itrap` one cycle later, with `trap_num` = 30 and `iaq_addr` = the fetch address, when it hits an enabled instruction set. A hit means every address bit whose mask bit is 0 equals the stored address. Address bits 31:24 are always compared. `fetch_nullified` has no effect.
- R4: `mem_kind` encodes 0 = load, 1 = store, 2 = semaphore, 3 = cache purge. A data set with its read enable set hits on a load or a semaphore access. The result is `dtrap` one cycle later, with `trap_num` = 31 and `ior_addr` = the access address.
- R5: A data set with its write enable set hits on a store, a semaphore access or a cache purge.
- R6: A nullified memory access never raises a data trap. A data set with both enables clear never hits.
- R7: With `dbg_en` low, neither trap is raised.
- R8: `instr_off` high suppresses the instruction trap, and `data_off` high suppresses the data trap, each for the cycle in which it is high.
- R9: At most one trap is signalled per cycle. When instruction and data hits coincide, only the instruction trap is raised. `trap_num` is 0 when no trap is signalled.
- R10: A bus access while `unit_en` is low raises `assist_req` in the next cycle and leaves the watch registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Enables register-bus access to the unit |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| assist_req | output | 1 | Access attempted while the unit is disabled |
| dbg_en | input | 1 | Global debug trap enable |
| instr_off | input | 1 | One-shot instruction-trap disable |
| data_off | input | 1 | One-shot data-trap disable |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_addr | input | 32 | Fetch address |
| fetch_nullified | input | 1 | Fetched instruction is nullified |
| mem_valid | input | 1 | Memory access this cycle |
| mem_addr | input | 32 | Access address |
| mem_kind | input | 2 | Access type |
| mem_nullified | input | 1 | Access belongs to a nullified instruction |
| itrap | output | 1 | Instruction debug trap |
| dtrap | output | 1 | Data debug trap |
| trap_num | output | 5 | Interruption number of the signalled trap |
| iaq_addr | output | 32 | Address of the last instruction trap |
| ior_addr | output | 32 | Address of the last data trap |

## Verification
The hardest case to reach is a cycle in which an instruction hit and a data hit coincide. The data set's type enables must line up with the access kind, and the one-shot and global gates must all be open. Only then does priority decide the result. The stimulus first arms both kinds of set through the bus and confirms each one fires alone. It then drives a matching fetch and a matching store in the same cycle and expects only the instruction trap. The mask boundary is also exercised. A full-ones mask must still compare the upper eight address bits, so the stimulus sends one address that differs only in the low bits and one that differs in bit 24.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
    localparam int ADDR_W  = 32;
    localparam int EXACT_W = 8;
    localparam int MASK_W  = ADDR_W - EXACT_W;
    localparam int NUM_W   = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_SEMA  = 2'd2,
        ACC_PURGE = 2'd3
    } acc_kind_e;

    localparam logic [NUM_W-1:0] TRAP_NUM_NONE  = 5'd0;
    localparam logic [NUM_W-1:0] TRAP_NUM_INSTR = 5'd30;
    localparam logic [NUM_W-1:0] TRAP_NUM_DATA  = 5'd31;
endpackage

// File: rtl/dwu_regs.sv
module dwu_regs
    import dwu_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int N_DBP = 2,
    parameter int IDX_W = $clog2(2 * (N_IBP + N_DBP))
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              unit_en,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [IDX_W-1:0]                  bus_idx,
    input  logic [ADDR_W-1:0]                 bus_wdata,
    output logic [ADDR_W-1:0]                 bus_rdata,
    output logic                              assist_req,
    output logic [N_IBP-1:0][ADDR_W-1:0]      ioff,
    output logic [N_IBP-1:0]                  ien,
    output logic [N_IBP-1:0][MASK_W-1:0]      imask,
    output logic [N_DBP-1:0][ADDR_W-1:0]      doff,
    output logic [N_DBP-1:0]                  drd,
    output logic [N_DBP-1:0]                  dwr,
    output logic [N_DBP-1:0][MASK_W-1:0]      dmask
);
    localparam int DBASE = 2 * N_IBP;

    typedef struct packed {
        logic [N_IBP-1:0][ADDR_W-1:0] ioff;
        logic [N_IBP-1:0]             ien;
        logic [N_IBP-1:0][MASK_W-1:0] imask;
        logic [N_DBP-1:0][ADDR_W-1:0] doff;
        logic [N_DBP-1:0]             drd;
        logic [N_DBP-1:0]             dwr;
        logic [N_DBP-1:0][MASK_W-1:0] dmask;
        logic [ADDR_W-1:0]            rdata;
        logic                         assist;
    } regs_t;

    regs_t s_d, s_q;
    logic [ADDR_W-1:0] rd_word;

    // Read mux: control words are rebuilt with reserved bits forced low
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_IBP; i++) begin
            if (int'(bus_idx) == 2 * i)
                rd_word = s_q.ioff[i];
            if (int'(bus_idx) == 2 * i + 1)
                rd_word = {s_q.ien[i], {(EXACT_W-1){1'b0}}, s_q.imask[i]};
        end
        for (int j = 0; j < N_DBP; j++) begin
            if (int'(bus_idx) == DBASE + 2 * j)
                rd_word = s_q.doff[j];
            if (int'(bus_idx) == DBASE + 2 * j + 1)
                rd_word = {s_q.drd[j], s_q.dwr[j], {(EXACT_W-2){1'b0}}, s_q.dmask[j]};
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.assist = bus_sel && !unit_en;
        if (bus_sel && unit_en) begin
            if (bus_wr) begin
                for (int i = 0; i < N_IBP; i++) begin
                    if (int'(bus_idx) == 2 * i)
                        s_d.ioff[i] = bus_wdata;
                    if (int'(bus_idx) == 2 * i + 1) begin
                        s_d.ien[i]   = bus_wdata[ADDR_W-1];
                        s_d.imask[i] = bus_wdata[MASK_W-1:0];
                    end
                end
                for (int j = 0; j < N_DBP; j++) begin
                    if (int'(bus_idx) == DBASE + 2 * j)
                        s_d.doff[j] = bus_wdata;
                    if (int'(bus_idx) == DBASE + 2 * j + 1) begin
                        s_d.drd[j]   = bus_wdata[ADDR_W-1];
                        s_d.dwr[j]   = bus_wdata[ADDR_W-2];
                        s_d.dmask[j] = bus_wdata[MASK_W-1:0];
                    end
                end
            end else begin
                s_d.rdata = rd_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata  = s_q.rdata;
    assign assist_req = s_q.assist;
    assign ioff       = s_q.ioff;
    assign ien        = s_q.ien;
    assign imask      = s_q.imask;
    assign doff       = s_q.doff;
    assign drd        = s_q.drd;
    assign dwr        = s_q.dwr;
    assign dmask      = s_q.dmask;
endmodule

// File: rtl/dwu_addr_cmp.sv
module dwu_addr_cmp
    import dwu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [MASK_W-1:0] dont_care,
    output logic              hit
);
    logic [ADDR_W-1:0] care;

    always_comb begin
        care = {{EXACT_W{1'b1}}, ~dont_care};
        hit  = ((addr ^ ref_addr) & care) == '0;
    end
endmodule

// File: rtl/dwu_trap_sel.sv
module dwu_trap_sel
    import dwu_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int N_DBP = 2
) (
    input  logic             fetch_valid,
    input  logic [N_IBP-1:0] ihit,
    input  logic [N_IBP-1:0] ien,
    input  logic             mem_valid,
    input  logic             mem_nullified,
    input  logic [1:0]       mem_kind,
    input  logic [N_DBP-1:0] dhit,
    input  logic [N_DBP-1:0] drd,
    input  logic [N_DBP-1:0] dwr,
    input  logic             dbg_en,
    input  logic             instr_off,
    input  logic             data_off,
    output logic             take_instr,
    output logic             take_data
);
    logic             kind_rd, kind_wr;
    logic [N_IBP-1:0] iarm;
    logic [N_DBP-1:0] darm;
    logic             data_raw;

    always_comb begin
        kind_rd = (mem_kind == ACC_LOAD) || (mem_kind == ACC_SEMA);
        kind_wr = (mem_kind == ACC_STORE) || (mem_kind == ACC_SEMA)
                || (mem_kind == ACC_PURGE);
        iarm    = ihit & ien;
        darm    = dhit & ((drd & {N_DBP{kind_rd}}) | (dwr & {N_DBP{kind_wr}}));
        take_instr = fetch_valid && (|iarm) && dbg_en && !instr_off;
        data_raw   = mem_valid && !mem_nullified && (|darm) && dbg_en && !data_off;
        take_data  = data_raw && !take_instr;
    end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dwu_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int N_DBP = 2,
    parameter int IDX_W = $clog2(2 * (N_IBP + N_DBP))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              assist_req,
    input  logic              dbg_en,
    input  logic              instr_off,
    input  logic              data_off,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    input  logic              fetch_nullified,
    input  logic              mem_valid,
    input  logic [31:0]       mem_addr,
    input  logic [1:0]        mem_kind,
    input  logic              mem_nullified,
    output logic              itrap,
    output logic              dtrap,
    output logic [4:0]        trap_num,
    output logic [31:0]       iaq_addr,
    output logic [31:0]       ior_addr
);
    logic [N_IBP-1:0][ADDR_W-1:0] ioff;
    logic [N_IBP-1:0]             ien;
    logic [N_IBP-1:0][MASK_W-1:0] imask;
    logic [N_DBP-1:0][ADDR_W-1:0] doff;
    logic [N_DBP-1:0]             drd, dwr;
    logic [N_DBP-1:0][MASK_W-1:0] dmask;
    logic [N_IBP-1:0]             ihit;
    logic [N_DBP-1:0]             dhit;
    logic                         take_instr, take_data;

    // nullification does not gate instruction matches
    logic unused_fetch_null;
    assign unused_fetch_null = fetch_nullified;

    dwu_regs #(.N_IBP(N_IBP), .N_DBP(N_DBP), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .assist_req(assist_req),
        .ioff(ioff), .ien(ien), .imask(imask),
        .doff(doff), .drd(drd), .dwr(dwr), .dmask(dmask)
    );

    for (genvar gi = 0; gi < N_IBP; gi++) begin : g_icmp
        dwu_addr_cmp u_cmp (
            .addr(fetch_addr), .ref_addr(ioff[gi]),
            .dont_care(imask[gi]), .hit(ihit[gi])
        );
    end

    for (genvar gj = 0; gj < N_DBP; gj++) begin : g_dcmp
        dwu_addr_cmp u_cmp (
            .addr(mem_addr), .ref_addr(doff[gj]),
            .dont_care(dmask[gj]), .hit(dhit[gj])
        );
    end

    dwu_trap_sel #(.N_IBP(N_IBP), .N_DBP(N_DBP)) u_sel (
        .fetch_valid(fetch_valid), .ihit(ihit), .ien(ien),
        .mem_valid(mem_valid), .mem_nullified(mem_nullified), .mem_kind(mem_kind),
        .dhit(dhit), .drd(drd), .dwr(dwr),
        .dbg_en(dbg_en), .instr_off(instr_off), .data_off(data_off),
        .take_instr(take_instr), .take_data(take_data)
    );

    typedef struct packed {
        logic              itrap;
        logic              dtrap;
        logic [NUM_W-1:0]  num;
        logic [ADDR_W-1:0] iaq;
        logic [ADDR_W-1:0] ior;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.itrap = take_instr;
        o_d.dtrap = take_data;
        o_d.num   = TRAP_NUM_NONE;
        if (take_instr) begin
            o_d.num = TRAP_NUM_INSTR;
            o_d.iaq = fetch_addr;
        end else if (take_data) begin
            o_d.num = TRAP_NUM_DATA;
            o_d.ior = mem_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign itrap    = o_q.itrap;
    assign dtrap    = o_q.dtrap;
    assign trap_num = o_q.num;
    assign iaq_addr = o_q.iaq;
    assign ior_addr = o_q.ior;
endmodule

// File: rtl/dwu_chk.sv
module dwu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       unit_en,
    input logic       bus_sel,
    input logic       dbg_en,
    input logic       instr_off,
    input logic       data_off,
    input logic       fetch_valid,
    input logic       mem_valid,
    input logic       mem_nullified,
    input logic       itrap,
    input logic       dtrap,
    input logic [4:0] trap_num,
    input logic       assist_req
);
    // R9
    single_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(itrap && dtrap));
    // R3
    inum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        itrap |-> trap_num == 5'd30);
    // R4
    dnum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtrap |-> trap_num == 5'd31);
    // R9
    idle_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!itrap && !dtrap) |-> trap_num == 5'd0);
    // R7
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |=> (!itrap && !dtrap));
    // R8
    ishot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_off |=> !itrap);
    // R8
    dshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_off |=> !dtrap);
    // R6
    null_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid || mem_nullified) |=> !dtrap);
    // R3
    no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !itrap);
    // R10
    assist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !unit_en) |=> assist_req);
    // R10
    no_assist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || unit_en) |=> !assist_req);
endmodule

bind dbg_watch_unit dwu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .bus_sel(bus_sel),
    .dbg_en(dbg_en), .instr_off(instr_off), .data_off(data_off),
    .fetch_valid(fetch_valid), .mem_valid(mem_valid),
    .mem_nullified(mem_nullified), .itrap(itrap), .dtrap(dtrap),
    .trap_num(trap_num), .assist_req(assist_req)
);

// File: tb/dbg_watch_unit_test.sv
`timescale 1ns/1ps
module dbg_watch_unit_test;
    logic        clk = 0;
    logic        rst_n;
    logic        unit_en, bus_sel, bus_wr;
    logic [2:0]  bus_idx;
    logic [31:0] bus_wdata, bus_rdata;
    logic        assist_req, dbg_en, instr_off, data_off;
    logic        fetch_valid, fetch_nullified, mem_valid, mem_nullified;
    logic [31:0] fetch_addr, mem_addr, iaq_addr, ior_addr;
    logic [1:0]  mem_kind;
    logic        itrap, dtrap;
    logic [4:0]  trap_num;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dbg_watch_unit uut (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .assist_req(assist_req), .dbg_en(dbg_en),
        .instr_off(instr_off), .data_off(data_off), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_nullified(fetch_nullified),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_kind(mem_kind),
        .mem_nullified(mem_nullified), .itrap(itrap), .dtrap(dtrap),
        .trap_num(trap_num), .iaq_addr(iaq_addr), .ior_addr(ior_addr)
    );

    typedef struct {
        logic        itrap;
        logic        dtrap;
        logic [4:0]  num;
        logic [31:0] addr;
        logic        assist;
        logic        chk_rd;
        logic [31:0] rdata;
        string       req;
    } item_t;

    item_t expq[$];
    item_t mi;

    // reference copies of the watch registers, kept from the R2 layout
    logic [31:0] m_reg [8];

    function automatic logic hits(input logic [31:0] a, input logic [31:0] ref_a,
                                  input logic [23:0] dc);
        return ((a ^ ref_a) & {8'hFF, ~dc}) == 32'h0;
    endfunction

    task automatic idle();
        bus_sel = 0; bus_wr = 0; bus_idx = 0; bus_wdata = 0;
        fetch_valid = 0; fetch_addr = 0; fetch_nullified = 0;
        mem_valid = 0; mem_addr = 0; mem_kind = 0; mem_nullified = 0;
    endtask

    task automatic step(input string req);
        item_t it;
        logic  ih, dh, krd, kwr;
        ih = 0;
        dh = 0;
        if (fetch_valid)
            for (int i = 0; i < 2; i++)
                if (m_reg[2*i+1][31] && hits(fetch_addr, m_reg[2*i], m_reg[2*i+1][23:0]))
                    ih = 1;
        krd = (mem_kind == 2'd0) || (mem_kind == 2'd2);
        kwr = (mem_kind != 2'd0);
        if (mem_valid && !mem_nullified)
            for (int j = 0; j < 2; j++)
                if (hits(mem_addr, m_reg[4+2*j], m_reg[5+2*j][23:0]) &&
                    ((m_reg[5+2*j][31] && krd) || (m_reg[5+2*j][30] && kwr)))
                    dh = 1;
        ih = ih && dbg_en && !instr_off;
        dh = dh && dbg_en && !data_off && !ih;
        it.itrap  = ih;
        it.dtrap  = dh;
        it.num    = ih ? 5'd30 : (dh ? 5'd31 : 5'd0);
        it.addr   = ih ? fetch_addr : mem_addr;
        it.assist = bus_sel && !unit_en;
        it.chk_rd = bus_sel && unit_en && !bus_wr;
        it.rdata  = m_reg[bus_idx];
        it.req    = req;
        if (bus_sel && unit_en && bus_wr)
            m_reg[bus_idx] = bus_idx[0] ? (bus_idx[2] ? (bus_wdata & 32'hC0FF_FFFF)
                                                      : (bus_wdata & 32'h80FF_FFFF))
                                        : bus_wdata;
        expq.push_back(it);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input string req);
        bus_sel = 1; bus_wr = 1; bus_idx = 3'(idx); bus_wdata = d;
        step(req);
    endtask

    task automatic rd(input int idx, input string req);
        bus_sel = 1; bus_wr = 0; bus_idx = 3'(idx);
        step(req);
    endtask

    task automatic fetch(input logic [31:0] a, input logic nul, input string req);
        fetch_valid = 1; fetch_addr = a; fetch_nullified = nul;
        step(req);
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic nul,
                       input string req);
        mem_valid = 1; mem_addr = a; mem_kind = k; mem_nullified = nul;
        step(req);
    endtask

    // monitor: compares the registered outputs shortly after each edge
    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            mi = expq.pop_front();
            checks++;
            if (itrap !== mi.itrap || dtrap !== mi.dtrap || trap_num !== mi.num ||
                assist_req !== mi.assist ||
                (mi.itrap && iaq_addr !== mi.addr) ||
                (mi.dtrap && ior_addr !== mi.addr) ||
                (mi.chk_rd && bus_rdata !== mi.rdata)) begin
                fails++;
                $display("FAIL %s: got i=%0b d=%0b num=%0d as=%0b iaq=%h ior=%h rd=%h; exp i=%0b d=%0b num=%0d as=%0b addr=%h rd=%h",
                         mi.req, itrap, dtrap, trap_num, assist_req, iaq_addr, ior_addr,
                         bus_rdata, mi.itrap, mi.dtrap, mi.num, mi.assist, mi.addr, mi.rdata);
            end
        end
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
        idle();
        rst_n = 0; unit_en = 1; dbg_en = 0; instr_off = 0; data_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (itrap !== 0 || dtrap !== 0 || assist_req !== 0 || trap_num !== 0) begin
            fails++;
            $display("FAIL R1 reset outputs: i=%0b d=%0b as=%0b num=%0d exp all 0",
                     itrap, dtrap, assist_req, trap_num);
        end
        for (int i = 0; i < 8; i++) rd(i, "R1 reset readback");

        // R2 layout and reserved bits
        wr(0, 32'h1000_0040, "R2 write iaddr0");
        wr(1, 32'hFF00_000F, "R2 write ictl0");
        rd(1, "R2 ictl0 reserved read zero");
        rd(0, "R2 iaddr0 readback");
        wr(5, 32'hFF00_00FF, "R2 write dctl0");
        rd(5, "R2 dctl0 reserved read zero");
        wr(5, 32'h8000_00FF, "R2 dctl0 read-only");
        wr(4, 32'h2000_0000, "R2 write daddr0");

        dbg_en = 1;
        // R3 instruction hits
        fetch(32'h1000_0045, 0, "R3 masked low bits hit");
        fetch(32'h1000_0055, 0, "R3 unmasked bit differs");
        fetch(32'h1100_0040, 0, "R3 upper bits differ");
        fetch(32'h1000_0040, 1, "R3 nullified fetch still hits");
        wr(2, 32'h0A00_0000, "R3 write iaddr1");
        wr(3, 32'h80FF_FFFF, "R3 full mask");
        fetch(32'h0A12_3456, 0, "R3 full mask low bits ignored");
        fetch(32'h0B00_0000, 0, "R3 bit 24 still compared");

        // R7 and R8
        dbg_en = 0;
        fetch(32'h1000_0040, 0, "R7 global off instr");
        acc(32'h2000_0010, 2'd0, 0, "R7 global off data");
        dbg_en = 1;
        instr_off = 1;
        fetch(32'h1000_0040, 0, "R8 instr one-shot");
        instr_off = 0;
        fetch(32'h1000_0040, 0, "R8 instr after one-shot cleared");

        // R4 read-enabled data set
        acc(32'h2000_0010, 2'd0, 0, "R4 load hits");
        acc(32'h2000_0010, 2'd1, 0, "R4 store misses read-only set");
        acc(32'h2000_0020, 2'd2, 0, "R4 semaphore hits");
        acc(32'h2000_0100, 2'd0, 0, "R4 unmasked bit differs");
        acc(32'h2000_0010, 2'd0, 1, "R6 nullified load");

        // R5 write-enabled data set
        wr(6, 32'h3000_0000, "R5 write daddr1");
        wr(7, 32'h4000_0000, "R5 dctl1 write-only");
        acc(32'h3000_0000, 2'd1, 0, "R5 store hits");
        acc(32'h3000_0000, 2'd3, 0, "R5 purge hits");
        acc(32'h3000_0000, 2'd2, 0, "R5 semaphore hits");
        acc(32'h3000_0000, 2'd0, 0, "R5 load misses write-only set");
        data_off = 1;
        acc(32'h3000_0000, 2'd1, 0, "R8 data one-shot");
        data_off = 0;

        // R9 priority
        fetch_valid = 1; fetch_addr = 32'h1000_0040;
        mem_valid = 1; mem_addr = 32'h3000_0000; mem_kind = 2'd1;
        step("R9 instr beats data");
        wr(2, 32'h1000_0040, "R9 second iset same addr");
        fetch(32'h1000_0041, 0, "R9 two isets one trap");
        acc(32'h2000_0000, 2'd0, 0, "R9 data trap number");

        // R10 unit disabled
        unit_en = 0;
        wr(1, 32'h0000_0000, "R10 write while disabled");
        rd(1, "R10 read while disabled");
        unit_en = 1;
        rd(1, "R10 ictl0 unchanged");
        fetch(32'h1000_0043, 0, "R10 breakpoint still armed");

        // R6 disabled data set
        wr(5, 32'h0000_00FF, "R6 clear both enables");
        acc(32'h2000_0010, 2'd0, 0, "R6 load on disabled set");
        acc(32'h2000_0010, 2'd2, 0, "R6 semaphore on disabled set");

        @(posedge clk);
        #3;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule